// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Code Register File

This block is the digital host-side store for an eight-channel, 13-bit converter. A host presents a data word and a channel number, then strobes an active-low select and an active-low write line. On the write line's rising edge, while select is low, the word goes into that channel's input register. A second rank, the DAC registers, feeds the converter codes.

The DAC registers follow their input registers for as long as the active-low load line is held low. A host can therefore stage all eight channels first and then update them together. Holding load low permanently gives an update on every write.

An active-low clear line asserts a per-channel force-to-ground flag for every channel. This happens combinationally and without any clock. Clear leaves both register ranks untouched, so each output returns to its stored code when clear is released. The select, write and load strobes are treated as synchronous to a fast system clock and pass through a two-flop synchronizer before use. The address and data travel through a matching two-stage delay so that they stay aligned with the strobes.

Top module: `dac_bank_regs`

## Requirements
- R1: In the cycle after synchronous reset `rst` is sampled high, all input registers and all DAC registers hold zero and every `gnd_force` bit is low.
- R2: A rising edge on `wr_n` while `cs_n` is low writes `din` into the input register of channel `addr` (0 is the first channel, 7 the last). `din` bit 12 is the MSB. Channel i's code appears on `dac_code[i*13 +: 13]`.
- R3: A rising edge on `wr_n` while `cs_n` is high changes no input register.
- R4: While `ld_n` is high, no DAC register changes, even when input registers are written.
- R5: While `ld_n` is low, every DAC register takes the value its input register held one cycle earlier, on every clock.
- R6: With `ld_n` held low, a written value shows on `dac_code` at the fourth rising clock edge after the rising edge of `wr_n` is driven. It is not visible at the third.
- R7: While `clr_n` is low, all eight `gnd_force` bits are high, without waiting for a clock edge.
- R8: Holding `clr_n` low changes no input register and no DAC register.
- R9: While `clr_n` is high, all `gnd_force` bits are low, and each output shows its DAC register code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe; data is captured on its rising edge |
| ld_n | input | 1 | Active-low transparent load from input rank to DAC rank |
| clr_n | input | 1 | Active-low asynchronous force-to-ground |
| addr | input | 3 | Channel number for a write |
| din | input | 13 | Data word, bit 12 MSB |
| dac_code | output | 104 | Eight DAC register codes, channel i at bits i*13 +: 13 |
| gnd_force | output | 8 | Per-channel flag forcing the output to ground level |

## Verification
The bound checker checks several rules on every clock. It confirms that a detected write edge lands in the addressed input register and that no input register moves without one. It confirms that the DAC rank is frozen while the synchronized load is high and copies the input rank while it is low. It also confirms that the ground flags track the clear line exactly. Some behaviour is only visible from the pins over a sequence, and the bench scenarios cover it. This includes the exact four-edge write-to-output latency, a write with select high being ignored, stage-then-load updates across all channels, and codes surviving a clear unchanged.

// File: rtl/dacr_pkg.sv
package dacr_pkg;
  // Strobes that share one synchronizer bank
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic ld_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1};
endpackage

// File: rtl/dacr_sync.sv
module dacr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dacr_wr_edge.sv
module dacr_wr_edge (
  input  logic clk,
  input  logic rst,
  input  logic wr_s,
  input  logic cs_s,
  output logic cap
);
  logic wr_prev;

  always_ff @(posedge clk) begin
    if (rst) wr_prev <= 1'b1;
    else     wr_prev <= wr_s;
  end

  // Rising write edge qualified by select low at that edge
  assign cap = wr_s & ~wr_prev & ~cs_s;
endmodule

// File: rtl/dacr_chan.sv
module dacr_chan #(
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  input  logic          xfer,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] dac_q
);
  always_ff @(posedge clk) begin
    if (rst)      in_q <= '0;
    else if (wen) in_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       dac_q <= '0;
    else if (xfer) dac_q <= in_q;
  end
endmodule

// File: rtl/dac_bank_regs.sv
module dac_bank_regs #(
  parameter int NCH = 8,
  parameter int DW  = 13,
  parameter int AW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]    gnd_force
);
  import dacr_pkg::*;

  localparam int SW = $bits(strobe_t);
  localparam int PW = AW + DW;

  strobe_t          strobe_raw, strobe_s;
  logic [PW-1:0]    bus_s;
  logic [AW-1:0]    cap_addr;
  logic [DW-1:0]    cap_data;
  logic             wr_cap;
  logic             ld_sync;
  logic [NCH*DW-1:0] in_flat;
  logic [NCH*DW-1:0] dac_flat;

  assign strobe_raw = '{cs_n: cs_n, wr_n: wr_n, ld_n: ld_n};

  dacr_sync #(.W(SW), .STAGES(2), .RST_VAL(STROBE_IDLE)) u_strobe_sync (
    .clk(clk), .rst(rst), .d(strobe_raw), .q(strobe_s)
  );

  // Address/data delayed to stay aligned with the synchronized strobes
  dacr_sync #(.W(PW), .STAGES(2), .RST_VAL('0)) u_bus_dly (
    .clk(clk), .rst(rst), .d({addr, din}), .q(bus_s)
  );

  assign cap_addr = bus_s[PW-1:DW];
  assign cap_data = bus_s[DW-1:0];
  assign ld_sync  = ~strobe_s.ld_n;

  dacr_wr_edge u_edge (
    .clk(clk), .rst(rst), .wr_s(strobe_s.wr_n), .cs_s(strobe_s.cs_n), .cap(wr_cap)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      dacr_chan #(.DW(DW)) u_chan (
        .clk  (clk),
        .rst  (rst),
        .wen  (wr_cap && (cap_addr == AW'(c))),
        .wdata(cap_data),
        .xfer (ld_sync),
        .in_q (in_flat[c*DW +: DW]),
        .dac_q(dac_flat[c*DW +: DW])
      );
    end
  endgenerate

  assign dac_code  = dac_flat;
  assign gnd_force = {NCH{~clr_n}};
endmodule

// File: rtl/dac_bank_regs_chk.sv
module dac_bank_regs_chk #(
  parameter int NCH = 8,
  parameter int DW  = 13,
  parameter int AW  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_n,
  input logic              wr_cap,
  input logic              ld_sync,
  input logic [AW-1:0]     cap_addr,
  input logic [DW-1:0]     cap_data,
  input logic [NCH*DW-1:0] in_flat,
  input logic [NCH*DW-1:0] dac_flat,
  input logic [NCH-1:0]    gnd_force
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    addr_q <= cap_addr;
    data_q <= cap_data;
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (in_flat == '0 && dac_flat == '0));

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    wr_cap |=> (in_flat[int'(addr_q)*DW +: DW] == data_q));

  assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_cap |=> $stable(in_flat));

  assert_dac_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !ld_sync |=> $stable(dac_flat));

  assert_dac_follow_R5: assert property (@(posedge clk) disable iff (rst)
    ld_sync |=> (dac_flat == $past(in_flat)));

  assert_clear_force_R7: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (gnd_force == '1));

  assert_clear_release_R9: assert property (@(posedge clk) disable iff (rst)
    clr_n |-> (gnd_force == '0));
endmodule

bind dac_bank_regs dac_bank_regs_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n), .wr_cap(wr_cap), .ld_sync(ld_sync),
  .cap_addr(cap_addr), .cap_data(cap_data), .in_flat(in_flat),
  .dac_flat(dac_flat), .gnd_force(gnd_force)
);

// File: tb/dac_bank_regs_bench.sv
module dac_bank_regs_bench;
  localparam int NCH = 8;
  localparam int DW  = 13;

  logic clk = 1'b0;
  logic rst, cs_n, wr_n, ld_n, clr_n;
  logic [2:0] addr;
  logic [DW-1:0] din;
  logic [NCH*DW-1:0] dac_code;
  logic [NCH-1:0] gnd_force;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_bank_regs u_dac_bank_regs (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n),
    .addr(addr), .din(din), .dac_code(dac_code), .gnd_force(gnd_force)
  );

  function automatic logic [DW-1:0] code_of(int ch);
    return dac_code[ch*DW +: DW];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_ch(logic [2:0] a, logic [DW-1:0] d, logic sel_n);
    @(negedge clk);
    cs_n = sel_n; addr = a; din = d; wr_n = 1'b0;
    cycles(3);
    wr_n = 1'b1;
    cycles(3);
    cs_n = 1'b1;
    cycles(2);
  endtask

  task automatic t_reset;
    rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1; clr_n = 1'b1;
    addr = '0; din = '0;
    cycles(3);
    rst = 1'b0;
    cycles(1);
    for (int c = 0; c < NCH; c++) check($sformatf("R1 code ch%0d", c), 32'(code_of(c)), 0);
    check("R1 gnd_force", 32'(gnd_force), 0);
  endtask

  task automatic t_stage_then_load;
    logic [DW-1:0] v [NCH];
    for (int c = 0; c < NCH; c++) v[c] = DW'(13'h1000 | (c * 13'h0123));
    v[7] = 13'h1FFF;
    for (int c = 0; c < NCH; c++) write_ch(3'(c), v[c], 1'b0);
    for (int c = 0; c < NCH; c++) check($sformatf("R4 hold ch%0d", c), 32'(code_of(c)), 0);
    @(negedge clk); ld_n = 1'b0;
    cycles(5);
    ld_n = 1'b1;
    cycles(3);
    for (int c = 0; c < NCH; c++) check($sformatf("R2 R5 load ch%0d", c), 32'(code_of(c)), 32'(v[c]));
  endtask

  task automatic t_cs_ignored;
    write_ch(3'd2, 13'h0AAA, 1'b1);
    @(negedge clk); ld_n = 1'b0;
    cycles(4);
    ld_n = 1'b1;
    cycles(3);
    check("R3 ignored ch2", 32'(code_of(2)), 32'(13'h1000 | (2 * 13'h0123)));
  endtask

  task automatic t_load_tied;
    @(negedge clk); ld_n = 1'b0;
    cycles(4);
    cs_n = 1'b0; addr = 3'd5; din = 13'h0155; wr_n = 1'b0;
    cycles(3);
    wr_n = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    check("R6 not yet at 3rd edge", 32'(code_of(5)), 32'(13'h1000 | (5 * 13'h0123)));
    @(posedge clk); #1;
    check("R6 visible at 4th edge", 32'(code_of(5)), 32'h155);
    cycles(2);
    cs_n = 1'b1;
    write_ch(3'd0, 13'h0001, 1'b0);
    check("R5 follow while low ch0", 32'(code_of(0)), 1);
    @(negedge clk); ld_n = 1'b1;
    cycles(3);
  endtask

  task automatic t_clear;
    logic [NCH*DW-1:0] snap;
    snap = dac_code;
    @(negedge clk); clr_n = 1'b0; #1;
    check("R7 force immediate", 32'(gnd_force), 32'hFF);
    cycles(6);
    check("R7 force held", 32'(gnd_force), 32'hFF);
    @(negedge clk); clr_n = 1'b1; #1;
    check("R9 release flags", 32'(gnd_force), 0);
    check("R8 codes kept lo", dac_code[31:0], snap[31:0]);
    check("R8 codes kept hi", dac_code[103:72], snap[103:72]);
    @(negedge clk); ld_n = 1'b0;
    cycles(4);
    ld_n = 1'b1;
    cycles(2);
    check("R8 R9 input rank kept ch5", 32'(code_of(5)), 32'h155);
    check("R8 R9 input rank kept ch7", 32'(code_of(7)), 32'h1FFF);
  endtask

  initial begin
    t_reset();
    t_stage_then_load();
    t_cs_ignored();
    t_load_tied();
    t_clear();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule